// File: doc/BRIEF.md
# Card Command Path Engine

This block issues a single command to a memory card over a one-bit serial command line and, when told to, collects the card's reply. Software first loads a 32-bit argument and then writes a command word. The word carries a 6-bit command index, a response-kind code, an expect-busy bit and an enable bit. The engine builds a 48-bit command frame protected by a CRC7, shifts it out at one bit per clock, and then either reports completion or waits for a reply on the command input. A reply is either a 48-bit short frame or a 136-bit long frame.

Once a reply has been accepted, the engine can also follow busy signalling on data line 0. It raises a live busy indication while the card holds that line low. When the line releases it sets a release flag, and if a busy timer runs out first it sets a data-timeout flag. Every outcome is recorded in sticky status flags, and software clears them by writing ones to a clear port. Reply payloads appear on four 32-bit response words.

Top module: `cmdpath_engine`

## Requirements
- R1: After reset, `cmd_out` is 1, `status` is 0 and all four response words are 0. Whenever `status[13]` is 0, `cmd_out` is 1.
- R2: Command word encoding is index [5:0], response kind [9:8], enable [12] and expect-busy [13]. Bits 6, 7, 10 and 11 have no effect. An accepted start makes `cmd_out` emit 48 bits, most significant bit first, starting the cycle after the write: 0, 1, the index, the argument, a CRC7 (polynomial x^7+x^3+1, zero seed) over the preceding 40 bits, and 1.
- R3: `status[13]` is 1 while a command is in progress. With response kind 00, `status[7]` is set in the cycle after the last frame bit, and no reply is awaited.
- R4: With kind 01, a 48-bit reply sets `status[6]` and loads `resp_w1` with reply bits 39:8 when the received bits 7:1 equal the CRC7 over reply bits 47:8. On a mismatch it sets `status[0]` instead of `status[6]`.
- R5: With kind 10, the reply CRC is not checked. A reply with a wrong CRC still sets `status[6]` and loads `resp_w1`.
- R6: With kind 11, a 136-bit reply loads `resp_w1`..`resp_w4` with reply bits 127:96, 95:64, 63:32 and {31:1, 0}. Only bits 7:1 are compared against the CRC7 over bits 127:8, with `status[6]` set on a match and `status[0]` set on a mismatch.
- R7: If no 0 start bit is seen on `cmd_in` within RESP_TIMEOUT clocks after the last frame bit, `status[2]` is set and the command ends.
- R8: With expect-busy set and a reply that passes its CRC check, `d0_in` low in the cycle after the reply makes `status[20]` high. When `d0_in` returns to 1, `status[21]` is set and `status[20]` drops.
- R9: If `d0_in` stays low for BUSY_LIMIT clocks after busy begins, `status[3]` is set and `status[20]` drops.
- R10: Writing `clr_wdata` with `clr_we` clears each sticky flag (bits 0, 2, 3, 6, 7, 21) whose bit is 1 and leaves the other flags unchanged.
- R11: A command write with the enable bit set is ignored while the enable bit remains set from an earlier start, even if that command has finished. A command write with enable 0 aborts any command in progress, returns `cmd_out` to 1 and allows a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| arg_we | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Command argument |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 14 | Command word |
| clr_we | input | 1 | Flag clear write strobe |
| clr_wdata | input | 32 | Write-one-to-clear mask |
| cmd_in | input | 1 | Serial reply line from card |
| d0_in | input | 1 | Data line 0 for busy signalling |
| cmd_out | output | 1 | Serial command line to card |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 |
| resp_w4 | output | 32 | Response word 4 |
| status | output | 32 | Sticky flags plus live active (13) and busy (20) bits |

## Verification
The bench keeps the reply timeout at its default of 64 clocks, so the last cycle before the timeout and the cycle it fires are both checked exactly. It lowers BUSY_LIMIT to 24, which brings the busy-timer expiry within a short run and lets the bench probe the cycle before expiry and the expiry cycle itself. Short and long replies are built with both correct and corrupted CRCs to show the difference between the checked and unchecked response kinds.

// File: rtl/cmdpath_pkg.sv
package cmdpath_pkg;

    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int LONG_HDR   = 8;   // bits ahead of the long payload
    localparam int CRC_TAIL   = 8;   // crc7 plus end bit
    localparam int WORD_W     = 32;
    localparam int CMDW_W     = 14;

    // status bit positions
    localparam int FLG_CRCERR = 0;
    localparam int FLG_RTMO   = 2;
    localparam int FLG_DTMO   = 3;
    localparam int FLG_REND   = 6;
    localparam int FLG_SENT   = 7;
    localparam int FLG_ACT    = 13;
    localparam int FLG_BUSY   = 20;
    localparam int FLG_BREL   = 21;

    localparam logic [WORD_W-1:0] STICKY_MASK =
        (WORD_W'(1) << FLG_CRCERR) | (WORD_W'(1) << FLG_RTMO) |
        (WORD_W'(1) << FLG_DTMO)   | (WORD_W'(1) << FLG_REND) |
        (WORD_W'(1) << FLG_SENT)   | (WORD_W'(1) << FLG_BREL);

    typedef enum logic [1:0] {
        RSP_NONE   = 2'b00,
        RSP_SHORT  = 2'b01,
        RSP_NOCRC  = 2'b10,
        RSP_LONG   = 2'b11
    } rsp_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SEND, PH_WAIT, PH_RECV, PH_CHECK, PH_BUSY
    } phase_e;

    typedef struct packed {
        logic       want_busy;   // 13
        logic       enable;      // 12
        logic [1:0] spare;       // 11:10
        rsp_kind_e  kind;        // 9:8
        logic       stop;        // 7
        logic       xfer;        // 6
        logic [5:0] index;       // 5:0
    } cmd_word_t;

    function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
        logic fb;
        fb = c[6] ^ b;
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_of40(logic [39:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
        return c;
    endfunction

endpackage

// File: rtl/cmdpath_tx.sv
module cmdpath_tx
    import cmdpath_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [5:0]  index,
    input  logic [31:0] arg,
    input  logic        shift,
    output logic        ser_bit,
    output logic        done
);
    localparam int CW = $clog2(SHORT_BITS);

    logic [SHORT_BITS-1:0] sh;
    logic [CW-1:0]         cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '1;
            cnt <= '0;
        end else if (load) begin
            sh  <= {2'b01, index, arg, crc7_of40({2'b01, index, arg}), 1'b1};
            cnt <= '0;
        end else if (shift) begin
            sh  <= {sh[SHORT_BITS-2:0], 1'b1};
            cnt <= cnt + 1'b1;
        end
    end

    assign ser_bit = sh[SHORT_BITS-1];
    assign done    = shift && (cnt == CW'(SHORT_BITS - 1));
endmodule

// File: rtl/cmdpath_rx.sv
module cmdpath_rx
    import cmdpath_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 shift,
    input  logic                 bit_in,
    input  logic                 long_mode,
    output logic [LONG_BITS-1:0] frame,
    output logic [6:0]           crc,
    output logic                 last
);
    localparam int IW = $clog2(LONG_BITS);

    logic [IW-1:0] idx;
    logic [IW-1:0] win_lo, win_hi, len_m1;
    logic          in_win;

    assign len_m1 = long_mode ? IW'(LONG_BITS - 1) : IW'(SHORT_BITS - 1);
    assign win_lo = long_mode ? IW'(LONG_HDR) : '0;
    assign win_hi = long_mode ? IW'(LONG_BITS - CRC_TAIL - 1)
                              : IW'(SHORT_BITS - CRC_TAIL - 1);
    assign in_win = (idx >= win_lo) && (idx <= win_hi);
    assign last   = shift && (idx == len_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
            crc   <= '0;
            idx   <= '0;
        end else if (start) begin
            frame <= '0;        // start bit is 0, crc of it from zero is 0
            crc   <= '0;
            idx   <= IW'(1);
        end else if (shift) begin
            frame <= {frame[LONG_BITS-2:0], bit_in};
            if (in_win) crc <= crc7_step(crc, bit_in);
            idx   <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/cmdpath_engine.sv
module cmdpath_engine
    import cmdpath_pkg::*;
#(
    parameter int RESP_TIMEOUT = 64,
    parameter int BUSY_LIMIT   = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        arg_we,
    input  logic [31:0] arg_wdata,
    input  logic        cmd_we,
    input  logic [13:0] cmd_wdata,
    input  logic        clr_we,
    input  logic [31:0] clr_wdata,
    input  logic        cmd_in,
    input  logic        d0_in,
    output logic        cmd_out,
    output logic [31:0] resp_w1,
    output logic [31:0] resp_w2,
    output logic [31:0] resp_w3,
    output logic [31:0] resp_w4,
    output logic [31:0] status
);
    localparam int TW = $clog2(RESP_TIMEOUT);
    localparam int BW = $clog2(BUSY_LIMIT);

    cmd_word_t              cw_in;
    phase_e                 ph;
    rsp_kind_e              kind_q;
    logic                   busy_q, en_latched;
    logic [5:0]             index_q;
    logic [31:0]            arg_q;
    logic [TW-1:0]          tcnt;
    logic [BW-1:0]          bcnt;
    logic [WORD_W-1:0]      sticky, ev;
    logic                   start_ok, abort, tx_bit, tx_done, rx_last, crc_bad;
    logic                   tmo_hit, btmo_hit;
    logic [LONG_BITS-1:0]   rx_frame;
    logic [6:0]             rx_crc;
    logic                   unused_bits;

    assign cw_in       = cmd_word_t'(cmd_wdata);
    assign unused_bits = ^{cw_in.xfer, cw_in.stop, cw_in.spare,
                           rx_frame[LONG_BITS-1:128], rx_frame[0]};
    assign abort       = cmd_we && !cw_in.enable;
    assign start_ok    = cmd_we && cw_in.enable && !en_latched;
    assign tmo_hit     = (tcnt == TW'(RESP_TIMEOUT - 1));
    assign btmo_hit    = (bcnt == BW'(BUSY_LIMIT - 1));
    assign crc_bad     = (kind_q == RSP_SHORT || kind_q == RSP_LONG) &&
                         (rx_crc != rx_frame[7:1]);

    cmdpath_tx u_tx (
        .clk(clk), .rst(rst), .load(start_ok), .index(cw_in.index),
        .arg(arg_q), .shift(ph == PH_SEND && !abort),
        .ser_bit(tx_bit), .done(tx_done)
    );

    cmdpath_rx u_rx (
        .clk(clk), .rst(rst),
        .start(ph == PH_WAIT && !cmd_in && !abort),
        .shift(ph == PH_RECV && !abort), .bit_in(cmd_in),
        .long_mode(kind_q == RSP_LONG),
        .frame(rx_frame), .crc(rx_crc), .last(rx_last)
    );

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            en_latched <= 1'b0;
            kind_q     <= RSP_NONE;
            busy_q     <= 1'b0;
            index_q    <= '0;
            arg_q      <= '0;
            tcnt       <= '0;
            bcnt       <= '0;
        end else begin
            if (arg_we) arg_q <= arg_wdata;
            if (abort) begin
                en_latched <= 1'b0;
                ph         <= PH_IDLE;
            end else if (start_ok) begin
                en_latched <= 1'b1;
                kind_q     <= cw_in.kind;
                busy_q     <= cw_in.want_busy;
                index_q    <= cw_in.index;
                ph         <= PH_SEND;
            end else begin
                unique case (ph)
                    PH_SEND: if (tx_done) begin
                        ph   <= (kind_q == RSP_NONE) ? PH_IDLE : PH_WAIT;
                        tcnt <= '0;
                    end
                    PH_WAIT: begin
                        if (!cmd_in)      ph <= PH_RECV;
                        else if (tmo_hit) ph <= PH_IDLE;
                        else              tcnt <= tcnt + 1'b1;
                    end
                    PH_RECV: if (rx_last) ph <= PH_CHECK;
                    PH_CHECK: begin
                        bcnt <= '0;
                        ph   <= (!crc_bad && busy_q && !d0_in) ? PH_BUSY : PH_IDLE;
                    end
                    PH_BUSY: begin
                        if (d0_in || btmo_hit) ph <= PH_IDLE;
                        else                   bcnt <= bcnt + 1'b1;
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    // flag events
    always_comb begin
        ev = '0;
        if (!abort) begin
            ev[FLG_SENT]   = (ph == PH_SEND) && tx_done && (kind_q == RSP_NONE);
            ev[FLG_RTMO]   = (ph == PH_WAIT) && cmd_in && tmo_hit;
            ev[FLG_CRCERR] = (ph == PH_CHECK) && crc_bad;
            ev[FLG_REND]   = (ph == PH_CHECK) && !crc_bad;
            ev[FLG_BREL]   = (ph == PH_BUSY) && d0_in;
            ev[FLG_DTMO]   = (ph == PH_BUSY) && !d0_in && btmo_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sticky <= '0;
        else     sticky <= ((sticky & ~(clr_we ? clr_wdata : '0)) | ev) & STICKY_MASK;
    end

    // response words
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_w1 <= '0; resp_w2 <= '0; resp_w3 <= '0; resp_w4 <= '0;
        end else if (ph == PH_CHECK && !abort) begin
            if (kind_q == RSP_LONG) begin
                resp_w1 <= rx_frame[127:96];
                resp_w2 <= rx_frame[95:64];
                resp_w3 <= rx_frame[63:32];
                resp_w4 <= {rx_frame[31:1], 1'b0};
            end else begin
                resp_w1 <= rx_frame[39:8];
            end
        end
    end

    always_comb begin
        status           = sticky;
        status[FLG_ACT]  = (ph != PH_IDLE);
        status[FLG_BUSY] = (ph == PH_BUSY);
    end

    assign cmd_out = (ph == PH_SEND) ? tx_bit : 1'b1;

    logic unused_index;
    assign unused_index = ^index_q;
endmodule

// File: rtl/cmdpath_engine_chk.sv
module cmdpath_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_out,
    input logic [31:0] status
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !status[13] |-> cmd_out);

    // R3
    sent_while_active_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[7]) |-> $past(status[13]) && !status[13]);

    // R4
    crc_excludes_rend_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> !$rose(status[6]));

    // R7
    timeout_ends_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> $past(status[13]) && !status[13]);

    // R8
    release_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[21]) |-> $past(status[20]) && !status[20]);

    // R9
    dtimeout_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[3]) |-> $past(status[20]) && !status[20]);
endmodule

bind cmdpath_engine cmdpath_engine_chk i_chk (
    .clk(clk), .rst(rst), .cmd_out(cmd_out), .status(status)
);

// File: tb/test_cmdpath_engine.sv
module test_cmdpath_engine;
    localparam int CLK_PERIOD = 10;
    localparam int RSP_TMO    = 64;
    localparam int BUSY_LIM   = 24;

    logic        clk = 1'b0;
    logic        rst, arg_we, cmd_we, clr_we, cmd_in, d0_in, cmd_out;
    logic [31:0] arg_wdata, clr_wdata, resp_w1, resp_w2, resp_w3, resp_w4, status;
    logic [13:0] cmd_wdata;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_q[$];
    bit   done = 0;

    cmdpath_engine #(.RESP_TIMEOUT(RSP_TMO), .BUSY_LIMIT(BUSY_LIM)) i_cmdpath_engine (
        .clk(clk), .rst(rst), .arg_we(arg_we), .arg_wdata(arg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .clr_we(clr_we),
        .clr_wdata(clr_wdata), .cmd_in(cmd_in), .d0_in(d0_in),
        .cmd_out(cmd_out), .resp_w1(resp_w1), .resp_w2(resp_w2),
        .resp_w3(resp_w3), .resp_w4(resp_w4), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: compares the serial line with the queued frame bits (R2)
    always begin
        @(negedge clk);
        #1;
        if (exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            n_chk++;
            if (cmd_out !== e) begin
                n_bad++;
                $display("FAIL R2: frame bit %0d act %b exp %b", exp_q.size(), cmd_out, e);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_of(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c;
        c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic fb;
            fb = c[6] ^ v[i];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] p);
        logic [135:0] f;
        f = '0;
        f[47:0] = {2'b00, idx, p, 7'h00, 1'b1};
        f[7:1] = crc_of(f, 47, 8);
        return f;
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] p);
        logic [135:0] f;
        f = {8'h3F, p, 7'h00, 1'b1};
        f[7:1] = crc_of(f, 127, 8);
        return f;
    endfunction

    task automatic wr_cmd(input logic [13:0] w);
        cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wr_arg(input logic [31:0] a);
        arg_we = 1'b1; arg_wdata = a;
        @(negedge clk);
        arg_we = 1'b0;
    endtask

    task automatic wr_clr(input logic [31:0] m);
        clr_we = 1'b1; clr_wdata = m;
        @(negedge clk);
        clr_we = 1'b0;
    endtask

    // driver: starts a command, queues its expected frame, waits out the frame
    task automatic issue(input logic [5:0] idx, input logic [1:0] kind,
                         input logic busy, input logic [31:0] arg);
        logic [135:0] f;
        wr_cmd('0);
        wr_arg(arg);
        f = '0;
        f[47:0] = {2'b01, idx, arg, 7'h00, 1'b1};
        f[7:1] = crc_of(f, 47, 8);
        wr_cmd({busy, 1'b1, 2'b00, kind, 2'b11, idx});
        for (int i = 47; i >= 0; i--) exp_q.push_back(f[i]);
        repeat (48) @(negedge clk);
    endtask

    task automatic send_resp(input logic [135:0] f, input int len, input int dly);
        repeat (dly) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_in = f[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act hung exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [135:0] f;
        rst = 1'b1; arg_we = 0; cmd_we = 0; clr_we = 0;
        arg_wdata = '0; cmd_wdata = '0; clr_wdata = '0;
        cmd_in = 1'b1; d0_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {31'b0, cmd_out}, 32'h1);
        chk("R1", status, 32'h0);
        chk("R1", resp_w1 | resp_w2 | resp_w3 | resp_w4, 32'h0);

        // R2 R3: no-response command
        issue(6'd0, 2'b00, 1'b0, 32'hA5C3_0F71);
        chk("R3", status, 32'h0000_0080);

        // R10: clear with other bit leaves flag, matching bit clears it
        wr_clr(32'h0000_0001);
        @(negedge clk);
        chk("R10", status, 32'h0000_0080);
        wr_clr(32'h0000_0080);
        chk("R10", status, 32'h0);

        // R11: enable still latched, new start ignored
        wr_cmd({1'b0, 1'b1, 2'b00, 2'b00, 2'b00, 6'd5});
        repeat (3) begin
            chk("R11", {status[13], cmd_out}, 32'h1);
            @(negedge clk);
        end

        // R4: short reply, good crc
        issue(6'd17, 2'b01, 1'b0, 32'h0000_0200);
        send_resp(mk_short(6'd17, 32'h1234_5678), 48, 3);
        chk("R4", status, 32'h0000_0040);
        chk("R4", resp_w1, 32'h1234_5678);
        wr_clr('1);

        // R4: short reply, bad crc
        issue(6'd13, 2'b01, 1'b0, 32'hDEAD_0001);
        f = mk_short(6'd13, 32'h0BAD_F00D);
        f[4] = ~f[4];
        send_resp(f, 48, 1);
        chk("R4", status, 32'h0000_0001);
        wr_clr('1);

        // R5: unchecked kind, bad crc still accepted
        issue(6'd41, 2'b10, 1'b0, 32'h0000_FFFF);
        f = mk_short(6'd41, 32'hCAFE_BEEF);
        f[2] = ~f[2];
        send_resp(f, 48, 0);
        chk("R5", status, 32'h0000_0040);
        chk("R5", resp_w1, 32'hCAFE_BEEF);
        wr_clr('1);

        // R6: long reply
        issue(6'd2, 2'b11, 1'b0, 32'h0);
        f = mk_long(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32);
        send_resp(f, 136, 5);
        chk("R6", status, 32'h0000_0040);
        chk("R6", resp_w1, f[127:96]);
        chk("R6", resp_w2, f[95:64]);
        chk("R6", resp_w3, f[63:32]);
        chk("R6", resp_w4, {f[31:1], 1'b0});
        wr_clr('1);

        // R6: long reply with bad crc
        issue(6'd9, 2'b11, 1'b0, 32'h5555_AAAA);
        f = mk_long(120'hF0F0_1111_2222_3333_4444_5555_6666_77);
        f[6] = ~f[6];
        send_resp(f, 136, 2);
        chk("R6", status, 32'h0000_0001);
        wr_clr('1);

        // R7: reply timeout boundary
        issue(6'd8, 2'b01, 1'b0, 32'h0000_01AA);
        repeat (RSP_TMO - 1) @(negedge clk);
        chk("R7", status, 32'h0000_2000);
        @(negedge clk);
        chk("R7", status, 32'h0000_0004);
        wr_clr('1);

        // R8: busy then release
        d0_in = 1'b0;
        issue(6'd12, 2'b01, 1'b1, 32'h0);
        send_resp(mk_short(6'd12, 32'h0000_0900), 48, 2);
        chk("R8", status, 32'h0010_2040);
        repeat (4) @(negedge clk);
        d0_in = 1'b1;
        @(negedge clk);
        chk("R8", status, 32'h0020_0040);
        wr_clr('1);

        // R9: busy timer expiry boundary
        d0_in = 1'b0;
        issue(6'd38, 2'b01, 1'b1, 32'h0);
        send_resp(mk_short(6'd38, 32'h0000_0800), 48, 1);
        chk("R9", status, 32'h0010_2040);
        repeat (BUSY_LIM - 1) @(negedge clk);
        chk("R9", status, 32'h0010_2040);
        @(negedge clk);
        chk("R9", status, 32'h0000_0048);
        d0_in = 1'b1;
        wr_clr('1);

        // R11 R3: abort in mid-frame
        wr_cmd('0);
        wr_cmd({1'b0, 1'b1, 2'b00, 2'b01, 2'b00, 6'd7});
        repeat (10) @(negedge clk);
        chk("R3", {31'b0, status[13]}, 32'h1);
        wr_cmd('0);
        chk("R11", {status[13], cmd_out}, 32'h1);
        repeat (RSP_TMO + 60) @(negedge clk);
        chk("R11", status, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule